// File: doc/BRIEF.md
# Exception vector entry unit

This unit handles exception entry for a small 32-bit soft processor. In any cycle the pipeline may present one exception request: a type code and the program counter of the instruction that raised it. In that same cycle the unit drives a register-file write that stores the return address in a link register, and a program-counter load to the handler address. At the clock edge that closes the cycle it updates a three-bit interrupt-enable register. Exceptions fall into two classes, normal and debug. Each class has its own link register and its own saved-enable bit.

The handler address is a base register plus the type code times 32. There are two programmable base registers, one for normal exceptions and one for debug. A remap control bit sends normal exceptions to the debug base. Software loads both bases, the remap bit and the enable register through a single-cycle register write port. A type code outside the defined set is an error. It does not vector. It sets a sticky error flag and leaves all other state as it was.

Top module: `exc_entry`

## Requirements
- R1: The handler address is the selected base plus the type code shifted left by 5 bits (code times 32). A normal exception with the remap bit clear uses the normal base.
- R2: When the remap bit is set, normal exceptions use the debug base. Debug exceptions use the debug base whatever the remap bit holds.
- R3: Codes 1 (instruction bus error), 2 (data bus error), 3 (divide by zero), 4 (external interrupt) and 5 (system call) are normal class. Codes 6 (breakpoint) and 7 (watchpoint) are debug class. Codes 0 and 8 to 15 are unrecognised.
- R4: A normal exception asserts `rf_we` with `rf_waddr` = 30 and `rf_wdata` = the request PC.
- R5: A debug exception asserts `rf_we` with `rf_waddr` = 31 and `rf_wdata` = the request PC.
- R6: After a normal exception, enable bit 1 (`ie_q[1]`, exception-saved) holds the previous global enable (`ie_q[0]`). The global enable is 0. Bit 2 is unchanged.
- R7: After a debug exception, enable bit 2 (`ie_q[2]`, break-saved) holds the previous global enable. The global enable is 0. Bit 1 is unchanged.
- R8: An unrecognised code asserts neither `pc_load` nor `rf_we` and leaves `ie_q` unchanged. It sets `err_q`, which stays set until reset.
- R9: Base writes clear bits 7:0 of the written value, so both bases stay 256-byte aligned.
- R10: `pc_load`, `pc_target` and the register-file write are valid in the request cycle itself. The enable and error registers change at the edge that ends that cycle.
- R11: After reset both bases are 0, the remap bit is 0, `ie_q` is 0 and `err_q` is 0.
- R12: Register writes use `cfg_sel`: 0 selects the normal base, 1 the debug base, 2 the remap bit (data bit 0) and 3 the enable register (data bits 2:0). A request in the same cycle sees the old values, and its enable update takes priority over an enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request, valid for one cycle |
| req_code | input | 4 | Exception type code |
| req_pc | input | 32 | PC of the excepting instruction |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| pc_load | output | 1 | Load the PC with `pc_target` |
| pc_target | output | 32 | Handler address |
| rf_we | output | 1 | Link register write enable |
| rf_waddr | output | 5 | Link register index |
| rf_wdata | output | 32 | Return address to save |
| ie_q | output | 3 | Enable register: bit0 global, bit1 exception-saved, bit2 break-saved |
| err_q | output | 1 | Sticky unrecognised-code flag |

## Verification
The bench goes after remap on debug codes. A design that wrongly lets the remap bit touch the debug path would still send those codes to the normal base. It checks requests that coincide with writes to a base or to the enable register. A design that forwards the new values would vector to the freshly written base, or would let the software write overwrite the enable update. Unrecognised codes come in while the global enable is set. A design that falls through to the normal path would clear the enable or write a link register. Bases written with nonzero low bytes expose any adder that keeps the stray bits, because they would appear in the handler address.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_DEBUG  = 2'd2
    } exc_class_e;

    localparam logic [CODE_W-1:0] CODE_IBUS_ERR = 4'd1;
    localparam logic [CODE_W-1:0] CODE_DBUS_ERR = 4'd2;
    localparam logic [CODE_W-1:0] CODE_DIV_ZERO = 4'd3;
    localparam logic [CODE_W-1:0] CODE_EXT_IRQ  = 4'd4;
    localparam logic [CODE_W-1:0] CODE_SYSCALL  = 4'd5;
    localparam logic [CODE_W-1:0] CODE_BREAK    = 4'd6;
    localparam logic [CODE_W-1:0] CODE_WATCH    = 4'd7;

    localparam logic [1:0] SEL_EXC_BASE = 2'd0;
    localparam logic [1:0] SEL_DBG_BASE = 2'd1;
    localparam logic [1:0] SEL_CTRL     = 2'd2;
    localparam logic [1:0] SEL_IE       = 2'd3;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output exc_class_e        cls
);
    always_comb begin
        unique case (code)
            CODE_IBUS_ERR,
            CODE_DBUS_ERR,
            CODE_DIV_ZERO,
            CODE_EXT_IRQ,
            CODE_SYSCALL:  cls = CLS_NORMAL;
            CODE_BREAK,
            CODE_WATCH:    cls = CLS_DEBUG;
            default:       cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VEC_SHIFT = 5
) (
    input  exc_class_e        cls,
    input  logic              remap,
    input  logic [XLEN-1:0]   exc_base,
    input  logic [XLEN-1:0]   dbg_base,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target
);
    localparam int PAD_W = XLEN - CODE_W - VEC_SHIFT;

    logic [XLEN-1:0] sel_base;
    logic [XLEN-1:0] offset;

    always_comb begin
        sel_base = (cls == CLS_DEBUG || remap) ? dbg_base : exc_base;
        offset   = {{PAD_W{1'b0}}, code, {VEC_SHIFT{1'b0}}};
        target   = sel_base + offset;
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int RF_AW      = 5,
    parameter int EA_IDX     = 30,
    parameter int BA_IDX     = 31,
    parameter int ALIGN_BITS = 8,
    parameter int VEC_SHIFT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_code,
    input  logic [XLEN-1:0]   req_pc,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [XLEN-1:0]   cfg_wdata,
    output logic              pc_load,
    output logic [XLEN-1:0]   pc_target,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [2:0]        ie_q,
    output logic              err_q
);
    localparam int IE_GLB = 0;
    localparam int IE_EXC = 1;
    localparam int IE_BRK = 2;
    localparam logic [RF_AW-1:0] EA_ADDR = RF_AW'(EA_IDX);
    localparam logic [RF_AW-1:0] BA_ADDR = RF_AW'(BA_IDX);

    typedef struct packed {
        logic [XLEN-1:0] exc_base;
        logic [XLEN-1:0] dbg_base;
        logic            remap;
        logic [2:0]      ie;
        logic            err;
    } state_t;

    state_t     st_q, st_d;
    exc_class_e cls;
    logic [XLEN-1:0] target;

    exc_classify u_cls (
        .code (req_code),
        .cls  (cls)
    );

    exc_target_gen #(
        .XLEN      (XLEN),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_tgt (
        .cls      (cls),
        .remap    (st_q.remap),
        .exc_base (st_q.exc_base),
        .dbg_base (st_q.dbg_base),
        .code     (req_code),
        .target   (target)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_EXC_BASE: st_d.exc_base = {cfg_wdata[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                SEL_DBG_BASE: st_d.dbg_base = {cfg_wdata[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                SEL_CTRL:     st_d.remap    = cfg_wdata[0];
                default:      st_d.ie       = cfg_wdata[2:0];
            endcase
        end
        if (req_valid) begin
            unique case (cls)
                CLS_NORMAL: begin
                    st_d.ie         = st_q.ie;
                    st_d.ie[IE_EXC] = st_q.ie[IE_GLB];
                    st_d.ie[IE_GLB] = 1'b0;
                end
                CLS_DEBUG: begin
                    st_d.ie         = st_q.ie;
                    st_d.ie[IE_BRK] = st_q.ie[IE_GLB];
                    st_d.ie[IE_GLB] = 1'b0;
                end
                default: begin
                    st_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pc_load   = req_valid && (cls != CLS_NONE);
        rf_we     = pc_load;
        pc_target = target;
        rf_wdata  = req_pc;
        rf_waddr  = '0;
        if (pc_load) begin
            rf_waddr = (cls == CLS_DEBUG) ? BA_ADDR : EA_ADDR;
        end
        ie_q  = st_q.ie;
        err_q = st_q.err;
    end

    // R6
    normal_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == EA_ADDR) |=>
            (ie_q[IE_EXC] == $past(ie_q[IE_GLB])) && !ie_q[IE_GLB]
            && (ie_q[IE_BRK] == $past(ie_q[IE_BRK])));

    // R7
    debug_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == BA_ADDR) |=>
            (ie_q[IE_BRK] == $past(ie_q[IE_GLB])) && !ie_q[IE_GLB]
            && (ie_q[IE_EXC] == $past(ie_q[IE_EXC])));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8
    bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pc_load && !cfg_we) |=> $stable(ie_q) && err_q);

    // R10
    load_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> req_valid && rf_we);

    // R9
    target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> pc_target[VEC_SHIFT-1:0] == '0);

endmodule

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_code;
    logic [31:0] req_pc;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        pc_load;
    logic [31:0] pc_target;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [2:0]  ie_q;
    logic        err_q;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_exc_base, m_dbg_base;
    logic        m_remap, m_err;
    logic [2:0]  m_ie;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_code(req_code), .req_pc(req_pc),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pc_load(pc_load), .pc_target(pc_target),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .ie_q(ie_q), .err_q(err_q)
    );

    // 0 unrecognised, 1 normal, 2 debug (R3)
    function automatic int f_class(input logic [3:0] c);
        if (c >= 4'd1 && c <= 4'd5) return 1;
        if (c == 4'd6 || c == 4'd7) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] f_target(input logic [3:0] c);
        logic [31:0] b;
        b = (f_class(c) == 2 || m_remap) ? m_dbg_base : m_exc_base;
        return b + ({28'd0, c} << 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] c, input logic [31:0] pc,
                        input logic we, input logic [1:0] sel, input logic [31:0] wd);
        int cl;
        logic [2:0] ie_n;
        req_valid = v; req_code = c; req_pc = pc;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        #2;
        cl = f_class(c);
        // R10 same-cycle outputs
        chk("R10 pc_load", {31'd0, pc_load}, {31'd0, v && cl != 0});
        chk("R10 rf_we", {31'd0, rf_we}, {31'd0, v && cl != 0});
        if (v && cl != 0) begin
            if (cl == 1 && m_remap) chk("R2 remapped target", pc_target, f_target(c));
            else if (cl == 2)       chk("R2 debug target", pc_target, f_target(c));
            else                    chk("R1 normal target", pc_target, f_target(c));
            if (cl == 1) chk("R4 link index", {27'd0, rf_waddr}, 32'd30);
            else         chk("R5 link index", {27'd0, rf_waddr}, 32'd31);
            chk("R4 R5 link data", rf_wdata, pc);
        end
        @(posedge clk);
        ie_n = m_ie;
        if (we) begin
            case (sel)
                2'd0: m_exc_base = wd & 32'hFFFF_FF00;
                2'd1: m_dbg_base = wd & 32'hFFFF_FF00;
                2'd2: m_remap = wd[0];
                default: ie_n = wd[2:0];
            endcase
        end
        if (v) begin
            if (cl == 1)      ie_n = {m_ie[2], m_ie[0], 1'b0};
            else if (cl == 2) ie_n = {m_ie[0], m_ie[1], 1'b0};
            else              m_err = 1'b1;
        end
        m_ie = ie_n;
        #1;
        if (v && cl == 0) chk("R8 ie unchanged", {29'd0, ie_q}, {29'd0, m_ie});
        else if (v && cl == 1) chk("R6 ie after normal", {29'd0, ie_q}, {29'd0, m_ie});
        else if (v && cl == 2) chk("R7 ie after debug", {29'd0, ie_q}, {29'd0, m_ie});
        else chk("R12 ie register", {29'd0, ie_q}, {29'd0, m_ie});
        chk("R8 err flag", {31'd0, err_q}, {31'd0, m_err});
    endtask

    initial begin
        req_valid = 0; req_code = 0; req_pc = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        m_exc_base = 0; m_dbg_base = 0; m_remap = 0; m_err = 0; m_ie = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #2;
        // R11 reset state
        chk("R11 ie reset", {29'd0, ie_q}, 32'd0);
        chk("R11 err reset", {31'd0, err_q}, 32'd0);
        step(1'b1, 4'd3, 32'h0000_1000, 1'b0, 2'd0, 32'd0); // R11 bases zero: target 0x60
        // R9 base writes drop low byte
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd0, 32'h1234_56FF);
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd1, 32'hABCD_EF81);
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd3, 32'h0000_0001);
        // R1 R4 R6 normal exception with global enable set
        step(1'b1, 4'd4, 32'h0000_2004, 1'b0, 2'd0, 32'd0);
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd3, 32'h0000_0001);
        // R5 R7 debug exception
        step(1'b1, 4'd7, 32'h0000_3008, 1'b0, 2'd0, 32'd0);
        // R2 remap with normal and debug codes
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd2, 32'h1);
        step(1'b1, 4'd1, 32'h0000_4000, 1'b0, 2'd0, 32'd0);
        step(1'b1, 4'd6, 32'h0000_4004, 1'b0, 2'd0, 32'd0);
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd2, 32'h0);
        // R12 request meets base write: old base used
        step(1'b1, 4'd5, 32'h0000_5000, 1'b1, 2'd0, 32'h7777_7700);
        step(1'b1, 4'd5, 32'h0000_5004, 1'b0, 2'd0, 32'd0);
        // R12 request meets enable write: request wins
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd3, 32'h0000_0001);
        step(1'b1, 4'd2, 32'h0000_6000, 1'b1, 2'd3, 32'h0000_0007);
        // R8 unrecognised codes with enable set
        step(1'b0, 4'd0, 32'd0, 1'b1, 2'd3, 32'h0000_0005);
        step(1'b1, 4'd0, 32'h0000_7000, 1'b0, 2'd0, 32'd0);
        step(1'b1, 4'd12, 32'h0000_7004, 1'b0, 2'd0, 32'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 2'd0, 32'd0);
        // random mix (R1-style checks inside step)
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] c;
            c = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'(1 + $urandom % 7);
            step(($urandom % 3) != 0, c, $urandom, ($urandom % 4) == 0,
                 2'($urandom % 4), $urandom);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R10 actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule